// File: doc/BRIEF.md
# Write-Allocate Eligibility Gate

This block decides, one cycle after it is shown a pending write, whether a write that misses in the L1 cache may cause a line allocation. The main grant comes from a programmable upper memory limit, counted in 4 MB steps. Two fixed windows are cut out of it: a legacy region from 640 KB to 1 MB, which the limit never grants, and a 1 MB hole from 15 MB to 16 MB, which the limit grants only when a hole-enable bit is set.

Two hint inputs come from separate allocation trackers: one for cacheable pages and one for same-sector writes. Each hint can grant allocation on its own, even when the limit test refuses the write. A hint still needs a valid, cacheable write that misses in L1. The limit and the hole-enable bit are held in a control register. A single-cycle write strobe loads it, and it clears to zero on reset, so after reset only the hints can grant allocation.

Top module: `wa_alloc_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `permit_o` is 0. The limit field and the hole bit both reset to 0.
- R2: When the limit field is 0, the limit test refuses every address. Only the hints can then produce `permit_o`=1.
- R3: An address is below the limit when `addr_i[31:22]` is less than the limit field. Such an address is granted by the limit test unless R5 or R6 excludes it.
- R4: An address whose `addr_i[31:22]` is equal to or greater than the limit field is never granted by the limit test.
- R5: Addresses 0x000A_0000 through 0x000F_FFFF are never granted by the limit test.
- R6: When the limit field is 4 or more (16 MB and up), addresses 0x00F0_0000 through 0x00FF_FFFF are granted by the limit test only when `cfg_hole_en_i` was written as 1.
- R7: When the limit field is below 4, the hole bit has no effect on `permit_o` for any address.
- R8: For a valid, cacheable write that misses in L1, `page_hint_i` or `sector_hint_i` at 1 grants allocation whatever the address and the configuration.
- R9: `permit_o` is 0 when the write is not valid, when it is not cacheable, or when it hits in L1. This holds even when the hints are 1.
- R10: `permit_o` is registered. It shows the decision for the inputs sampled at the previous rising clock edge.
- R11: A control write with `cfg_we_i`=1 is captured at a rising edge. It governs the decisions made from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_limit_i | input | 10 | Limit value to store, in 4 MB units |
| cfg_hole_en_i | input | 1 | Hole-enable value to store |
| wr_valid_i | input | 1 | A write is pending this cycle |
| addr_i | input | 32 | Physical write address |
| cacheable_i | input | 1 | The write targets a cacheable line |
| l1_hit_i | input | 1 | The line is present in L1 |
| page_hint_i | input | 1 | The cacheable-page tracker grants allocation |
| sector_hint_i | input | 1 | The same-sector tracker grants allocation |
| permit_o | output | 1 | Allocation permitted (registered) |

## Verification
The only state in the block is the limit field, the hole bit and the output register. A corrupted limit therefore shows up as a wrong grant or refusal just above or just below the programmed 4 MB boundary. This is visible one cycle after the first write that reaches that boundary. A stuck or inverted hole bit shows only for writes between 15 and 16 MB while the limit is 16 MB or more. A leak in either fixed window shows on the first write inside that window, again one cycle later. Because of this, the directed cases sit exactly on the edges of every window, and the random stimulus is weighted toward the low 32 MB.

// File: rtl/wa_pkg.sv
package wa_pkg;
  // fixed windows, byte addresses, upper bound exclusive
  localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
  localparam logic [31:0] LEGACY_HI = 32'h0010_0000;
  localparam logic [31:0] HOLE_LO   = 32'h00F0_0000;
  localparam logic [31:0] HOLE_HI   = 32'h0100_0000;

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/wa_cfg_reg.sv
module wa_cfg_reg #(
  parameter int unsigned LIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             hole_en_i,
  output logic [LIM_W-1:0] limit_o,
  output logic             hole_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_o   <= '0;
      hole_en_o <= 1'b0;
    end else if (we_i) begin
      limit_o   <= limit_i;
      hole_en_o <= hole_en_i;
    end
  end
endmodule

// File: rtl/wa_window_chk.sv
module wa_window_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIM_W      = 10,
  parameter int unsigned UNIT_SHIFT = 22
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              hole_en_i,
  output logic              lim_ok_o
);
  import wa_pkg::*;

  localparam int unsigned UNIT_W   = ADDR_W - UNIT_SHIFT;
  localparam int unsigned CMP_W    = (UNIT_W > LIM_W) ? UNIT_W : LIM_W;
  localparam int unsigned HOLE_LIM = 32'h0100_0000 >> UNIT_SHIFT;

  logic [CMP_W-1:0] unit_idx, lim_ext;
  logic [31:0]      a32;
  logic             below, in_legacy, in_hole, hole_armed;

  assign unit_idx = CMP_W'(addr_i >> UNIT_SHIFT);
  assign lim_ext  = CMP_W'(limit_i);
  assign a32      = 32'(addr_i);

  always_comb begin
    below      = unit_idx < lim_ext;
    in_legacy  = in_win(a32, LEGACY_LO, LEGACY_HI);
    in_hole    = in_win(a32, HOLE_LO, HOLE_HI);
    // hole bit only counts once the limit covers 16 MB
    hole_armed = (lim_ext >= CMP_W'(HOLE_LIM)) && hole_en_i;
    lim_ok_o   = below && !in_legacy && !(in_hole && !hole_armed);
  end
endmodule

// File: rtl/wa_decide.sv
module wa_decide (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  logic cacheable_i,
  input  logic l1_hit_i,
  input  logic lim_ok_i,
  input  logic page_hint_i,
  input  logic sector_hint_i,
  output logic permit_o
);
  logic eligible, permit_d;

  always_comb begin
    eligible = wr_valid_i && cacheable_i && !l1_hit_i;
    permit_d = eligible && (lim_ok_i || page_hint_i || sector_hint_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) permit_o <= 1'b0;
    else         permit_o <= permit_d;
  end
endmodule

// File: rtl/wa_alloc_gate.sv
module wa_alloc_gate #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIM_W      = 10,
  parameter int unsigned UNIT_SHIFT = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic              cfg_hole_en_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cacheable_i,
  input  logic              l1_hit_i,
  input  logic              page_hint_i,
  input  logic              sector_hint_i,
  output logic              permit_o
);
  logic [LIM_W-1:0] limit_q;
  logic             hole_q;
  logic             lim_ok;

  wa_cfg_reg #(.LIM_W(LIM_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .limit_i(cfg_limit_i), .hole_en_i(cfg_hole_en_i),
    .limit_o(limit_q), .hole_en_o(hole_q)
  );

  wa_window_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .UNIT_SHIFT(UNIT_SHIFT)) u_win (
    .addr_i(addr_i), .limit_i(limit_q), .hole_en_i(hole_q), .lim_ok_o(lim_ok)
  );

  wa_decide u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .cacheable_i(cacheable_i), .l1_hit_i(l1_hit_i), .lim_ok_i(lim_ok),
    .page_hint_i(page_hint_i), .sector_hint_i(sector_hint_i), .permit_o(permit_o)
  );
endmodule

// File: rtl/wa_alloc_chk.sv
module wa_alloc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [LIM_W-1:0]  cfg_limit_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cacheable_i,
  input logic              l1_hit_i,
  input logic              page_hint_i,
  input logic              sector_hint_i,
  input logic [LIM_W-1:0]  limit_q,
  input logic              hole_q,
  input logic              permit_o
);
  logic elig, hint, in_leg, in_hole;
  assign elig    = wr_valid_i && cacheable_i && !l1_hit_i;
  assign hint    = page_hint_i || sector_hint_i;
  assign in_leg  = (32'(addr_i) >= 32'h000A_0000) && (32'(addr_i) < 32'h0010_0000);
  assign in_hole = (32'(addr_i) >= 32'h00F0_0000) && (32'(addr_i) < 32'h0100_0000);

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> !permit_o);
  p_zero_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_q == '0 && !hint) |=> !permit_o);
  p_legacy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_leg && !hint) |=> !permit_o);
  p_hole_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hole && !hole_q && !hint) |=> !permit_o);
  p_hint_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig && hint) |=> permit_o);
  p_ineligible_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !elig |=> !permit_o);
  p_cfg_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (limit_q == $past(cfg_limit_i)));
endmodule

bind wa_alloc_gate wa_alloc_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_limit_i(cfg_limit_i),
  .wr_valid_i(wr_valid_i), .addr_i(addr_i), .cacheable_i(cacheable_i),
  .l1_hit_i(l1_hit_i), .page_hint_i(page_hint_i), .sector_hint_i(sector_hint_i),
  .limit_q(limit_q), .hole_q(hole_q), .permit_o(permit_o)
);

// File: tb/sim_wa_alloc_gate.sv
`timescale 1ns/1ps
module sim_wa_alloc_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_limit_i = '0;
  logic        cfg_hole_en_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        cacheable_i = 1'b0;
  logic        l1_hit_i = 1'b0;
  logic        page_hint_i = 1'b0;
  logic        sector_hint_i = 1'b0;
  logic        permit_o;

  int unsigned n_chk = 0, n_fail = 0;
  logic [9:0]  m_lim = '0;
  logic        m_hole = 1'b0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;

  wa_alloc_gate u0 (.*);

  function automatic logic exp_permit(input logic [31:0] a, input logic v, input logic c,
      input logic h, input logic pg, input logic sc, input logic [9:0] lim, input logic he);
    logic lim_ok;
    lim_ok = (a[31:22] < lim)
          && !(a >= 32'hA0000 && a < 32'h100000)
          && !(a >= 32'hF00000 && a < 32'h1000000 && !(he && lim >= 10'd4));
    return v && c && !h && (lim_ok || pg || sc);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: permit_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [9:0] lim, input logic he);
    @(negedge clk_i);
    wr_valid_i = 0; cfg_we_i = 1; cfg_limit_i = lim; cfg_hole_en_i = he;
    @(negedge clk_i);
    cfg_we_i = 0;
    m_lim = lim; m_hole = he;
    check("R11", permit_o, 1'b0);
  endtask

  // drive at negedge, registered result visible at following negedge
  task automatic apply(input string req, input logic [31:0] a, input logic v,
      input logic c, input logic h, input logic pg, input logic sc);
    wr_valid_i = v; addr_i = a; cacheable_i = c; l1_hit_i = h;
    page_hint_i = pg; sector_hint_i = sc;
    @(negedge clk_i);
    check(req, permit_o, exp_permit(a, v, c, h, pg, sc, m_lim, m_hole));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: expired expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1", permit_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1", permit_o, 1'b0);
    apply("R1", 32'h0000_1000, 1, 1, 0, 0, 0);
    apply("R2", 32'h0000_0000, 1, 1, 0, 0, 0);
    apply("R8", 32'h0000_0000, 1, 1, 0, 1, 0);
    apply("R8", 32'h0003_0000, 1, 1, 0, 0, 1);
    // limit 20 MB
    cfg(10'd5, 1'b0);
    apply("R3", 32'h013F_FFFC, 1, 1, 0, 0, 0);
    apply("R4", 32'h0140_0000, 1, 1, 0, 0, 0);
    apply("R8", 32'h0140_0000, 1, 1, 0, 0, 1);
    apply("R10", 32'h0000_2000, 1, 1, 0, 0, 0);
    apply("R10", 32'h0000_2000, 0, 1, 0, 0, 0);
    apply("R5", 32'h0009_FFFF, 1, 1, 0, 0, 0);
    apply("R5", 32'h000A_0000, 1, 1, 0, 0, 0);
    apply("R5", 32'h000F_FFFF, 1, 1, 0, 0, 0);
    apply("R5", 32'h0010_0000, 1, 1, 0, 0, 0);
    apply("R8", 32'h000B_0000, 1, 1, 0, 1, 0);
    apply("R6", 32'h00EF_FFFF, 1, 1, 0, 0, 0);
    apply("R6", 32'h00F0_0000, 1, 1, 0, 0, 0);
    apply("R6", 32'h00FF_FFFF, 1, 1, 0, 0, 0);
    apply("R6", 32'h0100_0000, 1, 1, 0, 0, 0);
    apply("R9", 32'h0000_4000, 1, 0, 0, 1, 1);
    apply("R9", 32'h0000_4000, 1, 1, 1, 1, 1);
    apply("R9", 32'h0000_4000, 0, 1, 0, 1, 1);
    cfg(10'd5, 1'b1);
    apply("R6", 32'h00F0_0000, 1, 1, 0, 0, 0);
    apply("R6", 32'h00FF_FFFF, 1, 1, 0, 0, 0);
    apply("R5", 32'h000C_0000, 1, 1, 0, 0, 0);
    // limit 12 MB: hole bit must not matter
    cfg(10'd3, 1'b1);
    apply("R7", 32'h00BF_FFFF, 1, 1, 0, 0, 0);
    apply("R7", 32'h00F8_0000, 1, 1, 0, 0, 0);
    cfg(10'd3, 1'b0);
    apply("R7", 32'h00BF_FFFF, 1, 1, 0, 0, 0);
    apply("R7", 32'h00F8_0000, 1, 1, 0, 0, 0);
    // exactly 16 MB
    cfg(10'd4, 1'b1);
    apply("R6", 32'h00F4_0000, 1, 1, 0, 0, 0);
    apply("R4", 32'h0100_0000, 1, 1, 0, 0, 0);
    // maximum limit
    cfg(10'h3FF, 1'b0);
    apply("R3", 32'hFFBF_FFFF, 1, 1, 0, 0, 0);
    apply("R4", 32'hFFC0_0000, 1, 1, 0, 0, 0);
    cfg(10'd0, 1'b1);
    apply("R2", 32'h0020_0000, 1, 1, 0, 0, 0);
    apply("R2", 32'h00F0_0000, 1, 1, 0, 0, 0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      int sel;
      if ($urandom_range(0, 19) == 0) begin
        logic [9:0] l;
        l = ($urandom_range(0, 1) == 0) ? 10'($urandom_range(0, 10)) : 10'($urandom);
        cfg(l, 1'($urandom));
      end
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = $urandom_range(0, 32'h001F_FFFF);
        1: a = $urandom_range(32'h00E0_0000, 32'h0110_0000);
        2: a = $urandom_range(0, 32'h03FF_FFFF);
        default: a = $urandom;
      endcase
      apply("R3", a, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
            ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule